// File: doc/BRIEF.md
# Host Protected Area Limit

This block keeps two capacity limits for a disk-style storage device. The first is the fixed native maximum LBA. The second is the current maximum LBA, which the host can lower to hide a reserved region at the top of the medium. Every read or write that arrives as a decoded command is checked against the current maximum. An access that would reach past it is refused with an ID-not-found error before any transfer starts. The identify capacity the host sees is always one more than the current maximum.

The host moves the limit with a two-step handshake. First it reads the native maximum. The very next command must then be a set-maximum, and only in that position is it accepted as an address change. A set-maximum that arrives at any other point is decoded instead as a security subcommand: set password, lock, unlock or freeze. These subcommands are reduced to a password-present flag, a locked flag and a frozen flag.

Each address change carries a keep bit, which chooses between a persistent and a volatile limit. A persistent limit is copied into a shadow register that models on-medium storage and survives a power-on reset. A volatile limit is replaced by the shadow value at the next power-on reset. A separate format reset returns the shadow register to the native maximum.

Top module: `hpa_limit`

## Requirements
- R1: After a format reset, the current maximum equals the native maximum, the identify capacity equals native + 1, the locked flag is 0 and no response is valid.
- R2: A read-native command (op code 1) is answered one cycle later with a valid response, no abort, and the native maximum on the response LBA.
- R3: A set-maximum (op code 2) whose only preceding command was a read-native changes the current maximum to the command LBA and returns that LBA, whatever the feature code holds. Idle cycles in between do not count as commands.
- R4: A set-maximum address above the native maximum aborts and leaves the current maximum unchanged.
- R5: Any other command between the read-native and the set-maximum (op 0, 3 or 4, or another set-maximum) disarms the pair. A set-maximum with feature 0 then aborts and leaves the current maximum unchanged.
- R6: A read (op 3) or write (op 4) whose last sector, LBA + max(count,1) − 1, lies above the current maximum responds with abort = 1, ID-not-found = 1 and transfer = 0. Otherwise it responds with abort 0, ID-not-found 0 and transfer 1.
- R7: A limit set with keep = 1 survives a power-on reset. A limit set with keep = 0 is replaced by the last persistent limit at power-on reset. A hard reset leaves the current maximum unchanged in both cases.
- R8: After a limit is set in 48-bit form (ext = 1) below the native maximum, a 28-bit set-maximum aborts with no change. A 48-bit set-maximum to the native maximum removes that restriction.
- R9: When not armed, a 28-bit set-maximum decodes its feature code. 01h records a password. 02h locks, but only when a password is recorded. 03h unlocks. While locked, address changes abort.
- R10: Feature 04h freezes the limit: every later set-maximum aborts and the current maximum stays fixed until a power-on reset.
- R11: A power-on reset clears the password, the locked flag and the frozen flag. A hard reset keeps all three.
- R12: The identify capacity always equals the current maximum + 1.
- R13: A 48-bit set-maximum that is not armed aborts, because subcommands exist only in 28-bit form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fmt_rst | input | 1 | Synchronous format reset: shadow and current limit return to native, all flags clear |
| por | input | 1 | Synchronous power-on reset: current limit reloads from shadow, security flags clear |
| hrst | input | 1 | Synchronous hard/soft reset: disarms the pair, keeps limits and flags |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | 0 other, 1 read-native, 2 set-maximum, 3 read, 4 write |
| cmd_ext | input | 1 | 1 = 48-bit form of the command |
| cmd_feat | input | 8 | Feature code for set-maximum subcommands |
| cmd_lba | input | LBA_W | Command LBA |
| cmd_cnt | input | CNT_W | Sector count (0 is checked as one sector) |
| cmd_keep | input | 1 | 1 = new limit is persistent |
| rsp_valid | output | 1 | Response for the command of the previous cycle |
| rsp_abort | output | 1 | Command refused |
| rsp_idnf | output | 1 | Refused because the access exceeds the limit |
| rsp_xfer | output | 1 | Media access may proceed |
| rsp_lba | output | LBA_W | Native max for read-native, new limit for an accepted address change, else 0 |
| cur_max | output | LBA_W | Current maximum LBA |
| id_capacity | output | LBA_W+1 | Capacity reported to identify: current maximum + 1 |
| max_locked | output | 1 | Set-maximum lock is engaged |

## Verification
The bench builds the block with an 8-bit LBA, a 4-bit count and a native maximum of F0h. At that size, every start LBA combined with every count can be swept against several limits, including a limit of zero and the native maximum itself. This reaches the region between the native maximum and the top of the address space, and end sums that carry out of 8 bits. Directed sequences cover the handshake order, the keep bit across both reset kinds, the 48-bit restriction, and the password, lock and freeze rules.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    typedef enum logic [2:0] {
        OP_OTHER     = 3'd0,
        OP_RD_NATIVE = 3'd1,
        OP_SET_MAX   = 3'd2,
        OP_READ      = 3'd3,
        OP_WRITE     = 3'd4
    } hpa_op_e;

    localparam logic [7:0] FT_SET_PWD = 8'h01;
    localparam logic [7:0] FT_LOCK    = 8'h02;
    localparam logic [7:0] FT_UNLOCK  = 8'h03;
    localparam logic [7:0] FT_FREEZE  = 8'h04;

    typedef struct packed {
        logic abort;
        logic idnf;
        logic xfer;
    } hpa_status_t;

    function automatic logic is_media(input hpa_op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/hpa_access_chk.sv
module hpa_access_chk #(
    parameter int LBA_W = 48,
    parameter int CNT_W = 16
) (
    input  logic [LBA_W-1:0] lba,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LBA_W-1:0] limit,
    output logic             beyond
);
    localparam int SUM_W = ((LBA_W > CNT_W) ? LBA_W : CNT_W) + 1;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] last;

    always_comb begin
        // a zero count still touches the start sector
        span   = (cnt == '0) ? SUM_W'(1) : SUM_W'(cnt);
        last   = SUM_W'(lba) + span - SUM_W'(1);
        beyond = last > SUM_W'(limit);
    end
endmodule

// File: rtl/hpa_limit_regs.sv
module hpa_limit_regs #(
    parameter int               LBA_W      = 48,
    parameter logic [LBA_W-1:0] NATIVE_MAX = '1
) (
    input  logic             clk,
    input  logic             fmt_rst,
    input  logic             por,
    input  logic             take,
    input  logic             ext,
    input  logic             keep,
    input  logic [LBA_W-1:0] lba,
    output logic [LBA_W-1:0] cur,
    output logic             area_ext
);
    logic [LBA_W-1:0] shadow_q;
    logic             shadow_ext_q;
    logic [LBA_W-1:0] cur_q;
    logic             area_q;
    logic             area_nxt;

    // the 48-bit restriction only exists while something is hidden
    assign area_nxt = ext && (lba != NATIVE_MAX);

    always_ff @(posedge clk) begin
        if (fmt_rst) begin
            shadow_q     <= NATIVE_MAX;
            shadow_ext_q <= 1'b0;
            cur_q        <= NATIVE_MAX;
            area_q       <= 1'b0;
        end else if (por) begin
            cur_q  <= shadow_q;
            area_q <= shadow_ext_q;
        end else if (take) begin
            cur_q  <= lba;
            area_q <= area_nxt;
            if (keep) begin
                shadow_q     <= lba;
                shadow_ext_q <= area_nxt;
            end
        end
    end

    assign cur      = cur_q;
    assign area_ext = area_q;

    p_cur_le_native_r4: assert property (@(posedge clk) disable iff (fmt_rst)
        cur_q <= NATIVE_MAX);
    p_area_below_native_r8: assert property (@(posedge clk) disable iff (fmt_rst)
        area_q |-> (cur_q != NATIVE_MAX));
endmodule

// File: rtl/hpa_setmax_ctrl.sv
module hpa_setmax_ctrl
    import hpa_pkg::*;
#(
    parameter int               LBA_W      = 48,
    parameter logic [LBA_W-1:0] NATIVE_MAX = '1
) (
    input  logic             clk,
    input  logic             cold,
    input  logic             warm,
    input  logic             fire,
    input  hpa_op_e          op,
    input  logic             ext,
    input  logic [7:0]       feat,
    input  logic [LBA_W-1:0] lba,
    input  logic             area_ext,
    output logic             addr_take,
    output logic             set_abort,
    output logic             locked,
    output logic             frozen
);
    logic armed_q, pwd_q, lock_q, frz_q;
    logic is_set, blocked, sub_pass, sub_ok;

    always_comb begin
        is_set    = fire && (op == OP_SET_MAX);
        blocked   = lock_q || frz_q;
        addr_take = is_set && armed_q && !blocked
                    && !(area_ext && !ext) && (lba <= NATIVE_MAX);
        sub_pass  = 1'b0;
        if (!ext && !frz_q) begin
            case (feat)
                FT_SET_PWD: sub_pass = !lock_q;
                FT_LOCK:    sub_pass = pwd_q;
                FT_UNLOCK:  sub_pass = 1'b1;
                FT_FREEZE:  sub_pass = 1'b1;
                default:    sub_pass = 1'b0;
            endcase
        end
        sub_ok    = is_set && !armed_q && sub_pass;
        set_abort = is_set && !addr_take && !sub_ok;
    end

    always_ff @(posedge clk) begin
        if (cold) begin
            armed_q <= 1'b0;
            pwd_q   <= 1'b0;
            lock_q  <= 1'b0;
            frz_q   <= 1'b0;
        end else if (warm) begin
            armed_q <= 1'b0;
        end else if (fire) begin
            armed_q <= (op == OP_RD_NATIVE);
            if (sub_ok) begin
                case (feat)
                    FT_SET_PWD: pwd_q  <= 1'b1;
                    FT_LOCK:    lock_q <= 1'b1;
                    FT_UNLOCK:  lock_q <= 1'b0;
                    FT_FREEZE:  frz_q  <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end

    assign locked = lock_q;
    assign frozen = frz_q;

    p_lock_has_pwd_r9: assert property (@(posedge clk) disable iff (cold)
        lock_q |-> pwd_q);
    p_freeze_sticky_r10: assert property (@(posedge clk) disable iff (cold)
        frz_q |=> frz_q);
    p_warm_keeps_lock_r11: assert property (@(posedge clk) disable iff (cold)
        (warm && lock_q) |=> lock_q);
endmodule

// File: rtl/hpa_limit.sv
module hpa_limit
    import hpa_pkg::*;
#(
    parameter int               LBA_W      = 48,
    parameter int               CNT_W      = 16,
    parameter logic [LBA_W-1:0] NATIVE_MAX = LBA_W'(48'h0000_0EE7_C2AF)
) (
    input  logic             clk,
    input  logic             fmt_rst,
    input  logic             por,
    input  logic             hrst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_ext,
    input  logic [7:0]       cmd_feat,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic [CNT_W-1:0] cmd_cnt,
    input  logic             cmd_keep,
    output logic             rsp_valid,
    output logic             rsp_abort,
    output logic             rsp_idnf,
    output logic             rsp_xfer,
    output logic [LBA_W-1:0] rsp_lba,
    output logic [LBA_W-1:0] cur_max,
    output logic [LBA_W:0]   id_capacity,
    output logic             max_locked
);
    localparam int CAP_W = LBA_W + 1;

    hpa_op_e          op;
    logic             cold, fire;
    logic             addr_take, set_abort, frozen, area_ext, beyond, access;
    logic [LBA_W-1:0] cur_q;
    hpa_status_t      st_nxt, st_q;
    logic [LBA_W-1:0] lba_nxt, lba_q;
    logic             vld_q;

    assign op     = hpa_op_e'(cmd_op);
    assign cold   = fmt_rst | por;
    assign fire   = cmd_valid && !hrst;
    assign access = fire && is_media(op);

    hpa_setmax_ctrl #(.LBA_W(LBA_W), .NATIVE_MAX(NATIVE_MAX)) u_ctrl (
        .clk(clk), .cold(cold), .warm(hrst), .fire(fire), .op(op),
        .ext(cmd_ext), .feat(cmd_feat), .lba(cmd_lba), .area_ext(area_ext),
        .addr_take(addr_take), .set_abort(set_abort),
        .locked(max_locked), .frozen(frozen)
    );

    hpa_limit_regs #(.LBA_W(LBA_W), .NATIVE_MAX(NATIVE_MAX)) u_regs (
        .clk(clk), .fmt_rst(fmt_rst), .por(por), .take(addr_take),
        .ext(cmd_ext), .keep(cmd_keep), .lba(cmd_lba),
        .cur(cur_q), .area_ext(area_ext)
    );

    hpa_access_chk #(.LBA_W(LBA_W), .CNT_W(CNT_W)) u_chk (
        .lba(cmd_lba), .cnt(cmd_cnt), .limit(cur_q), .beyond(beyond)
    );

    always_comb begin
        st_nxt.idnf  = access && beyond;
        st_nxt.xfer  = access && !beyond;
        st_nxt.abort = set_abort || st_nxt.idnf;
        if (op == OP_RD_NATIVE)  lba_nxt = NATIVE_MAX;
        else if (addr_take)      lba_nxt = cmd_lba;
        else                     lba_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (cold || hrst) begin
            vld_q <= 1'b0;
            st_q  <= '0;
            lba_q <= '0;
        end else begin
            vld_q <= fire;
            st_q  <= fire ? st_nxt : '0;
            lba_q <= fire ? lba_nxt : '0;
        end
    end

    assign rsp_valid   = vld_q;
    assign rsp_abort   = st_q.abort;
    assign rsp_idnf    = st_q.idnf;
    assign rsp_xfer    = st_q.xfer;
    assign rsp_lba     = lba_q;
    assign cur_max     = cur_q;
    assign id_capacity = CAP_W'(cur_q) + CAP_W'(1);

    p_native_rsp_r2: assert property (@(posedge clk) disable iff (cold || hrst)
        (cmd_valid && op == OP_RD_NATIVE) |=>
            (rsp_valid && !rsp_abort && rsp_lba == NATIVE_MAX));
    p_idnf_no_xfer_r6: assert property (@(posedge clk) disable iff (cold)
        rsp_idnf |-> (rsp_abort && !rsp_xfer));
    p_frozen_holds_max_r10: assert property (@(posedge clk) disable iff (cold)
        frozen |=> $stable(cur_max));
endmodule

// File: tb/sim_hpa_limit.sv
module sim_hpa_limit;
    localparam int            LW  = 8;
    localparam int            CW  = 4;
    localparam logic [LW-1:0] NAT = 8'hF0;

    logic          clk = 1'b0;
    logic          fmt_rst = 1'b1, por = 1'b0, hrst = 1'b0;
    logic          cmd_valid = 1'b0, cmd_ext = 1'b0, cmd_keep = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [7:0]    cmd_feat = 8'h00;
    logic [LW-1:0] cmd_lba = '0;
    logic [CW-1:0] cmd_cnt = '0;
    logic          rsp_valid, rsp_abort, rsp_idnf, rsp_xfer, max_locked;
    logic [LW-1:0] rsp_lba, cur_max;
    logic [LW:0]   id_capacity;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hpa_limit #(.LBA_W(LW), .CNT_W(CW), .NATIVE_MAX(NAT)) u0 (
        .clk(clk), .fmt_rst(fmt_rst), .por(por), .hrst(hrst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ext(cmd_ext),
        .cmd_feat(cmd_feat), .cmd_lba(cmd_lba), .cmd_cnt(cmd_cnt),
        .cmd_keep(cmd_keep), .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
        .rsp_idnf(rsp_idnf), .rsp_xfer(rsp_xfer), .rsp_lba(rsp_lba),
        .cur_max(cur_max), .id_capacity(id_capacity), .max_locked(max_locked)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic ext, input logic [7:0] feat,
                         input logic [LW-1:0] lba, input logic [CW-1:0] cnt, input logic keep);
        @(negedge clk);
        cmd_op = op; cmd_ext = ext; cmd_feat = feat;
        cmd_lba = lba; cmd_cnt = cnt; cmd_keep = keep; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_limit(input logic [LW-1:0] lba, input logic ext, input logic keep);
        issue(3'd1, 1'b0, 8'h00, '0, '0, 1'b0);
        issue(3'd2, ext, 8'hA5, lba, '0, keep);
    endtask

    task automatic sub(input logic [7:0] feat);
        issue(3'd2, 1'b0, feat, '0, '0, 1'b0);
    endtask

    task automatic pulse_por();
        @(negedge clk); por = 1'b1; @(negedge clk); por = 1'b0;
    endtask

    task automatic pulse_hrst();
        @(negedge clk); hrst = 1'b1; @(negedge clk); hrst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        fmt_rst = 1'b0;
        // R1 R12: reset state
        check("R1 cur_max", cur_max, NAT);
        check("R12 capacity", id_capacity, 32'(NAT) + 1);
        check("R1 locked", max_locked, 0);
        check("R1 rsp_valid", rsp_valid, 0);

        // R2
        issue(3'd1, 1'b0, 8'h00, '0, '0, 1'b0);
        check("R2 valid/abort", {rsp_valid, rsp_abort}, 2'b10);
        check("R2 lba", rsp_lba, NAT);

        // R3: feature ignored when armed; idle cycle allowed in between
        issue(3'd1, 1'b0, 8'h00, '0, '0, 1'b0);
        @(negedge clk);
        issue(3'd2, 1'b0, 8'h55, 8'h80, '0, 1'b0);
        check("R3 abort", rsp_abort, 0);
        check("R3 cur_max", cur_max, 8'h80);
        check("R3 rsp_lba", rsp_lba, 8'h80);
        check("R12 capacity", id_capacity, 9'h81);

        // R4
        set_limit(8'hF5, 1'b0, 1'b0);
        check("R4 abort", rsp_abort, 1);
        check("R4 cur_max", cur_max, 8'h80);

        // R5
        issue(3'd1, 1'b0, 8'h00, '0, '0, 1'b0);
        issue(3'd0, 1'b0, 8'h00, '0, '0, 1'b0);
        issue(3'd2, 1'b0, 8'h00, 8'h40, '0, 1'b0);
        check("R5 abort", rsp_abort, 1);
        check("R5 cur_max", cur_max, 8'h80);
        issue(3'd1, 1'b0, 8'h00, '0, '0, 1'b0);
        issue(3'd3, 1'b0, 8'h00, 8'h00, 4'd1, 1'b0);
        issue(3'd2, 1'b0, 8'h00, 8'h40, '0, 1'b0);
        check("R5 abort after read", rsp_abort, 1);
        check("R5 cur_max after read", cur_max, 8'h80);

        // R6: sweep every start and count against several limits
        for (int k = 0; k < 4; k++) begin
            logic [LW-1:0] m;
            m = (k == 0) ? 8'h00 : (k == 1) ? 8'h37 : (k == 2) ? 8'h80 : NAT;
            set_limit(m, 1'b0, 1'b0);
            check("R6 limit set", cur_max, m);
            for (int a = 0; a < 256; a++) begin
                for (int c = 0; c < 16; c++) begin
                    int last;
                    logic over;
                    last = a + ((c == 0) ? 1 : c) - 1;
                    over = last > int'(m);
                    issue((c % 2 == 0) ? 3'd3 : 3'd4, 1'b0, 8'h00, LW'(a), CW'(c), 1'b0);
                    check("R6 abort/idnf/xfer", {rsp_abort, rsp_idnf, rsp_xfer},
                          {over, over, !over});
                end
            end
        end

        // R7: keep bit across reset kinds
        set_limit(8'h60, 1'b0, 1'b1);
        set_limit(8'h30, 1'b0, 1'b0);
        check("R7 volatile set", cur_max, 8'h30);
        pulse_hrst();
        check("R7 hrst keeps volatile", cur_max, 8'h30);
        pulse_por();
        check("R7 por restores persistent", cur_max, 8'h60);
        pulse_por();
        check("R7 persistent survives por", cur_max, 8'h60);
        set_limit(NAT, 1'b0, 1'b1);
        check("R7 restore native", cur_max, NAT);

        // R8
        set_limit(8'h90, 1'b1, 1'b0);
        check("R8 ext set", cur_max, 8'h90);
        set_limit(8'hA0, 1'b0, 1'b0);
        check("R8 28-bit abort", {rsp_abort, cur_max}, {1'b1, 8'h90});
        set_limit(NAT, 1'b1, 1'b0);
        check("R8 ext to native", {rsp_abort, cur_max}, {1'b0, NAT});
        set_limit(8'h50, 1'b0, 1'b0);
        check("R8 28-bit after removal", {rsp_abort, cur_max}, {1'b0, 8'h50});

        // R13
        issue(3'd0, 1'b0, 8'h00, '0, '0, 1'b0);
        issue(3'd2, 1'b1, 8'h01, 8'h20, '0, 1'b0);
        check("R13 unarmed ext abort", {rsp_abort, cur_max}, {1'b1, 8'h50});

        // R9
        sub(8'h02);
        check("R9 lock without pwd", {rsp_abort, max_locked}, 2'b10);
        sub(8'h01);
        check("R9 set pwd", rsp_abort, 0);
        sub(8'h02);
        check("R9 lock", {rsp_abort, max_locked}, 2'b01);
        set_limit(8'h70, 1'b0, 1'b0);
        check("R9 locked set abort", {rsp_abort, cur_max}, {1'b1, 8'h50});
        sub(8'h03);
        check("R9 unlock", {rsp_abort, max_locked}, 2'b00);
        set_limit(8'h70, 1'b0, 1'b0);
        check("R9 set after unlock", {rsp_abort, cur_max}, {1'b0, 8'h70});

        // R11
        sub(8'h02);
        check("R11 relock", max_locked, 1);
        pulse_hrst();
        check("R11 hrst keeps lock", max_locked, 1);
        pulse_por();
        check("R11 por clears lock", max_locked, 0);
        check("R7 por reload", cur_max, NAT);
        sub(8'h02);
        check("R11 pwd cleared by por", {rsp_abort, max_locked}, 2'b10);

        // R10
        sub(8'h04);
        check("R10 freeze", rsp_abort, 0);
        set_limit(8'h20, 1'b0, 1'b0);
        check("R10 frozen set", {rsp_abort, cur_max}, {1'b1, NAT});
        sub(8'h01);
        check("R10 frozen subcommand", rsp_abort, 1);
        pulse_hrst();
        set_limit(8'h20, 1'b0, 1'b0);
        check("R11 hrst keeps freeze", {rsp_abort, cur_max}, {1'b1, NAT});
        pulse_por();
        set_limit(8'h20, 1'b0, 1'b0);
        check("R10 por clears freeze", {rsp_abort, cur_max}, {1'b0, 8'h20});
        check("R12 capacity", id_capacity, 9'h21);

        finish_run();
    end
endmodule